// File: doc/BRIEF.md
# Slave Sync Timing and Field Detector

This block follows an external video timing source. It takes active-low horizontal and vertical sync inputs from a master, passes each through a two-flop synchroniser, and qualifies each falling edge only once the input has stayed low for a minimum number of clocks. From the qualified edges it keeps a horizontal position counter and a line counter. The clock runs at twice the pixel rate, so the horizontal counter counts pixels.

On each accepted vertical sync fall the block decides which field is starting. It looks at where the fall landed inside the current line, using the length of the previous complete line as the scale. A fall near a line boundary (start or expected end) starts field 1; a fall near the middle of the line starts field 2. The result drives a field identifier and a one-cycle field-start pulse. Short sync glitches and vertical edges that land outside both windows raise a one-cycle error pulse instead. All pins are plain control and status signals; there is no streamed data and so no valid/ready handshake or back-pressure.

Top module: `sync_slave_timing`

## Requirements
- R1: While `rst` is high, `h_count` and `v_count` are 0, `field_id` is 0, and `field_start` and `sync_err` are low.
- R2: Between accepted horizontal falls, `h_count` rises by exactly one on every second rising clock edge and holds on the edges in between.
- R3: An accepted horizontal sync fall loads `h_count` with 1 and raises `v_count` by one.
- R4: An accepted vertical sync fall loads `v_count` with 1. This applies whether or not a field is identified, and it wins over a horizontal fall in the same cycle.
- R5: The line reference L is the value of `h_count` just before an accepted horizontal fall, captured only when an earlier accepted horizontal fall exists. After reset L is 0, which means there is no reference yet.
- R6: With pos = `h_count` - 1 at an accepted vertical fall, pos < L/4 or L - L/4 <= pos < L + L/4 sets `field_id` to 0 (field 1) and gives a one-cycle `field_start` pulse. L/4 and L/2 are truncating shifts.
- R7: With L/2 - L/4 <= pos < L/2 + L/4 and R6 not met, the block sets `field_id` to 1 (field 2) and gives a one-cycle `field_start` pulse.
- R8: An accepted vertical fall with L = 0, or with pos outside both windows, leaves `field_id` unchanged, gives no `field_start`, and pulses `sync_err` for one cycle.
- R9: A sync input that is low for fewer than 2 synchronised clocks is ignored by the counters and the field logic, and pulses `sync_err` for one cycle after it returns high.
- R10: An input fall that stays low long enough acts on the counters at the fourth rising clock edge after the fall: two synchroniser stages, one edge stage and one qualification stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the pixel rate |
| rst | input | 1 | Synchronous reset, active high |
| hsync_n | input | 1 | External horizontal sync, active low, asynchronous |
| vsync_n | input | 1 | External vertical sync, active low, asynchronous |
| h_count | output | HCNT_W | Horizontal pixel position, 1 at line start |
| v_count | output | VCNT_W | Line number, 1 at field start |
| field_start | output | 1 | One-cycle pulse when a field is identified |
| field_id | output | 1 | 0 = field 1, 1 = field 2 |
| sync_err | output | 1 | One-cycle pulse on a short sync pulse or a misplaced vertical fall |

## Verification
The step assertions on both counters assume the master never lets a line or a field run long enough to wrap a counter. The field-start assertions assume vertical falls come at least two clocks apart, which the minimum low time already guarantees. The directed stimulus uses 200-clock lines (a reference of 100), a single long gap that stays far below the counter range, and sync pulses that are either well over the minimum or exactly one clock. It places vertical falls at chosen offsets so that each window edge case produces a single known outcome.

// File: rtl/sst_pkg.sv
package sst_pkg;
  typedef enum logic {
    FLD_ONE = 1'b0,
    FLD_TWO = 1'b1
  } field_e;
endpackage

// File: rtl/sst_edge_qual.sv
// Two-flop synchroniser, falling-edge detect and minimum-low qualification.
module sst_edge_qual #(
  parameter int MIN_LOW = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_n_i,
  output logic fall_o,
  output logic short_o
);
  localparam int LW = $clog2(MIN_LOW + 1);

  logic          meta_q, s_q, p_q;
  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q  <= 1'b1;
      s_q     <= 1'b1;
      p_q     <= 1'b1;
      low_cnt <= LW'(MIN_LOW);
    end else begin
      meta_q <= sync_n_i;
      s_q    <= meta_q;
      p_q    <= s_q;
      if (!s_q) begin
        if (p_q)
          low_cnt <= LW'(1);
        else if (low_cnt < LW'(MIN_LOW))
          low_cnt <= low_cnt + LW'(1);
      end
    end
  end

  // Accepted once the MIN_LOW-th low cycle is seen.
  assign fall_o  = !s_q && (p_q ? (MIN_LOW == 1) : (low_cnt == LW'(MIN_LOW - 1)));
  // Rising edge after a pulse that never reached MIN_LOW.
  assign short_o = s_q && !p_q && (low_cnt < LW'(MIN_LOW));
endmodule

// File: rtl/sst_hcount.sv
// Half-rate horizontal counter and previous-line length capture.
module sst_hcount #(
  parameter int HW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          h_evt,
  output logic [HW-1:0] h_count,
  output logic [HW-1:0] line_len
);
  logic phase_q;
  logic h_seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      h_count  <= '0;
      line_len <= '0;
      phase_q  <= 1'b0;
      h_seen_q <= 1'b0;
    end else if (h_evt) begin
      h_count  <= HW'(1);
      phase_q  <= 1'b0;
      h_seen_q <= 1'b1;
      if (h_seen_q) line_len <= h_count;
    end else begin
      phase_q <= ~phase_q;
      if (phase_q) h_count <= h_count + HW'(1);
    end
  end
endmodule

// File: rtl/sst_vcount.sv
// Line counter: vertical event loads one, horizontal event advances.
module sst_vcount #(
  parameter int VW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          h_evt,
  input  logic          v_evt,
  output logic [VW-1:0] v_count
);
  always_ff @(posedge clk) begin
    if (rst)        v_count <= '0;
    else if (v_evt) v_count <= VW'(1);
    else if (h_evt) v_count <= v_count + VW'(1);
  end
endmodule

// File: rtl/sst_field_detect.sv
// Classifies a vertical event by its position within the line.
module sst_field_detect
  import sst_pkg::*;
#(
  parameter int HW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          v_evt,
  input  logic [HW-1:0] h_count,
  input  logic [HW-1:0] line_len,
  output logic          field_start,
  output field_e        field_id,
  output logic          win_miss
);
  localparam int XW = HW + 1;

  logic [XW-1:0] pos, len, qtr, half;
  logic          near_edge, near_mid, have_ref;

  always_comb begin
    pos       = {1'b0, h_count} - XW'(1);
    len       = {1'b0, line_len};
    qtr       = len >> 2;
    half      = len >> 1;
    have_ref  = (line_len != '0);
    near_edge = (pos < qtr) || ((pos >= len - qtr) && (pos < len + qtr));
    near_mid  = (pos >= half - qtr) && (pos < half + qtr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      field_start <= 1'b0;
      field_id    <= FLD_ONE;
      win_miss    <= 1'b0;
    end else begin
      field_start <= 1'b0;
      win_miss    <= 1'b0;
      if (v_evt) begin
        if (!have_ref) begin
          win_miss <= 1'b1;
        end else if (near_edge) begin
          field_start <= 1'b1;
          field_id    <= FLD_ONE;
        end else if (near_mid) begin
          field_start <= 1'b1;
          field_id    <= FLD_TWO;
        end else begin
          win_miss <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sync_slave_timing.sv
module sync_slave_timing #(
  parameter int HCNT_W  = 12,
  parameter int VCNT_W  = 10,
  parameter int MIN_LOW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsync_n,
  input  logic              vsync_n,
  output logic [HCNT_W-1:0] h_count,
  output logic [VCNT_W-1:0] v_count,
  output logic              field_start,
  output logic              field_id,
  output logic              sync_err
);
  import sst_pkg::*;

  localparam int NSYNC = 2;  // index 0 horizontal, 1 vertical

  logic [NSYNC-1:0] sync_in, fall, short_p;
  logic             h_evt, v_evt;
  logic             short_q, win_miss;
  logic [HCNT_W-1:0] line_len;
  field_e           fid;

  assign sync_in = {vsync_n, hsync_n};

  for (genvar i = 0; i < NSYNC; i++) begin : g_qual
    sst_edge_qual #(.MIN_LOW(MIN_LOW)) u_qual (
      .clk     (clk),
      .rst     (rst),
      .sync_n_i(sync_in[i]),
      .fall_o  (fall[i]),
      .short_o (short_p[i])
    );
  end

  assign h_evt = fall[0];
  assign v_evt = fall[1];

  sst_hcount #(.HW(HCNT_W)) u_hcount (
    .clk     (clk),
    .rst     (rst),
    .h_evt   (h_evt),
    .h_count (h_count),
    .line_len(line_len)
  );

  sst_vcount #(.VW(VCNT_W)) u_vcount (
    .clk    (clk),
    .rst    (rst),
    .h_evt  (h_evt),
    .v_evt  (v_evt),
    .v_count(v_count)
  );

  sst_field_detect #(.HW(HCNT_W)) u_field (
    .clk        (clk),
    .rst        (rst),
    .v_evt      (v_evt),
    .h_count    (h_count),
    .line_len   (line_len),
    .field_start(field_start),
    .field_id   (fid),
    .win_miss   (win_miss)
  );

  always_ff @(posedge clk) begin
    if (rst) short_q <= 1'b0;
    else     short_q <= |short_p;
  end

  assign field_id = fid;
  assign sync_err = short_q | win_miss;
endmodule

// File: rtl/sst_checker.sv
module sst_checker #(
  parameter int HW = 12,
  parameter int VW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic [HW-1:0] h_count,
  input logic [VW-1:0] v_count,
  input logic          field_start,
  input logic          field_id
);
  AST_HCOUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(h_count) |-> (h_count == HW'($past(h_count) + 1'b1)) || (h_count == HW'(1))); // R2

  AST_HCOUNT_PACE: assert property (@(posedge clk) disable iff (rst)
    (!$stable(h_count) && (h_count == HW'($past(h_count) + 1'b1))) |=> ($stable(h_count) || (h_count == HW'(1)))); // R2

  AST_VCOUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(v_count) |-> (v_count == VW'($past(v_count) + 1'b1)) || (v_count == VW'(1))); // R3

  AST_FIELD_LINE_ONE: assert property (@(posedge clk) disable iff (rst)
    field_start |-> (v_count == VW'(1))); // R4

  AST_FIELD_PULSE: assert property (@(posedge clk) disable iff (rst)
    field_start |=> !field_start); // R6

  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !field_start |-> $stable(field_id)); // R8
endmodule

bind sync_slave_timing sst_checker #(.HW(HCNT_W), .VW(VCNT_W)) u_sst_checker (
  .clk        (clk),
  .rst        (rst),
  .h_count    (h_count),
  .v_count    (v_count),
  .field_start(field_start),
  .field_id   (field_id)
);

// File: tb/tb_sync_slave_timing.sv
`timescale 1ns/1ps
module tb_sync_slave_timing;
  localparam int HW   = 12;
  localparam int VW   = 10;
  localparam int LINE = 200;  // clocks per line -> reference of 100

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hsync_n = 1'b1;
  logic          vsync_n = 1'b1;
  logic [HW-1:0] h_count;
  logic [VW-1:0] v_count;
  logic          field_start, field_id, sync_err;

  int  checks = 0, errors = 0, fs_cnt = 0, err_cnt = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  sync_slave_timing #(.HCNT_W(HW), .VCNT_W(VW), .MIN_LOW(2)) dut (
    .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .h_count(h_count), .v_count(v_count), .field_start(field_start),
    .field_id(field_id), .sync_err(sync_err)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (field_start) fs_cnt++;
      if (sync_err)    err_cnt++;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drives len clocks: H low for hw clocks at 0, V low for vw clocks at voff.
  task automatic drive(int len, int hw, int voff, int vw,
                       output int hc4, output int hc10, output int vc10);
    hc4 = -1; hc10 = -1; vc10 = -1;
    for (int n = 0; n < len; n++) begin
      hsync_n = !(n < hw);
      vsync_n = !((vw > 0) && (n >= voff) && (n < voff + vw));
      @(negedge clk);
      if (n + 1 == 4)  hc4 = int'(h_count);
      if (n + 1 == 10) begin
        hc10 = int'(h_count);
        vc10 = int'(v_count);
      end
    end
    hsync_n = 1'b1;
    vsync_n = 1'b1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (5) @(negedge clk);
    check("R1", "h_count", int'(h_count), 0);
    check("R1", "v_count", int'(v_count), 0);
    check("R1", "field_id", int'(field_id), 0);
    check("R1", "field_start", int'(field_start), 0);
    check("R1", "sync_err", int'(sync_err), 0);
    rst = 1'b0;
  endtask

  task automatic t_no_reference();
    int a, b, c, fs0, e0;
    fs0 = fs_cnt; e0 = err_cnt;
    drive(20, 0, 2, 6, a, b, c);
    check("R8", "no-ref field_start pulses", fs_cnt - fs0, 0);
    check("R8", "no-ref sync_err pulses", err_cnt - e0, 1);
    check("R8", "no-ref field_id", int'(field_id), 0);
    check("R4", "no-ref v_count load", int'(v_count), 1);
  endtask

  task automatic t_reference_lines();
    int hc4, hc10, vc10;
    drive(LINE, 4, 0, 0, hc4, hc10, vc10);
    check("R10", "h_count at 4th edge", hc4, 1);
    check("R2", "h_count at 10th edge", hc10, 4);
    check("R3", "v_count after first line", vc10, 2);
    drive(LINE, 4, 0, 0, hc4, hc10, vc10);
    check("R3", "v_count after second line", vc10, 3);
    check("R2", "h_count at line end", int'(h_count), 99);
  endtask

  task automatic t_field(int voff, int exp_id, string req, output int vc10);
    int hc4, hc10, fs0, e0;
    fs0 = fs_cnt; e0 = err_cnt;
    drive(LINE, 4, voff, 6, hc4, hc10, vc10);
    check(req, $sformatf("field_id voff=%0d", voff), int'(field_id), exp_id);
    check(req, $sformatf("field_start pulses voff=%0d", voff), fs_cnt - fs0, 1);
    check(req, $sformatf("sync_err pulses voff=%0d", voff), err_cnt - e0, 0);
  endtask

  task automatic t_field_sequence();
    int vc;
    t_field(0, 0, "R6", vc);
    check("R4", "v_count with coincident falls", vc, 1);
    t_field(100, 1, "R7", vc);
    t_field(20, 0, "R6", vc);
    check("R4", "v_count one line after mid-line load", vc, 2);
    t_field(60, 1, "R7", vc);
    t_field(160, 0, "R6", vc);
    t_field(140, 1, "R7", vc);
  endtask

  task automatic t_short_h();
    int hc4, hc10, vc10, fs0, e0;
    fs0 = fs_cnt; e0 = err_cnt;
    drive(LINE, 1, 0, 0, hc4, hc10, vc10);
    check("R9", "h_count not reloaded by short H", hc10, 104);
    check("R9", "v_count not advanced by short H", vc10, 1);
    check("R9", "short H sync_err pulses", err_cnt - e0, 1);
    check("R9", "short H field_start pulses", fs_cnt - fs0, 0);
  endtask

  task automatic t_reference_update();
    int vc;
    // Reference here is 200 (two lines since last accepted H): pos 49 < 50.
    t_field(100, 0, "R5", vc);
    // Reference now 100 again: pos 49 lies in the middle window.
    t_field(100, 1, "R5", vc);
  endtask

  task automatic t_short_v();
    int hc4, hc10, vc10, fs0, e0;
    fs0 = fs_cnt; e0 = err_cnt;
    drive(LINE, 4, 100, 1, hc4, hc10, vc10);
    check("R9", "short V field_start pulses", fs_cnt - fs0, 0);
    check("R9", "short V sync_err pulses", err_cnt - e0, 1);
    check("R9", "short V field_id", int'(field_id), 1);
    check("R9", "short V v_count not reloaded", int'(v_count), 2);
  endtask

  task automatic t_window_miss();
    int hc4, hc10, vc10, fs0, e0;
    fs0 = fs_cnt; e0 = err_cnt;
    drive(300, 0, 260, 6, hc4, hc10, vc10);
    check("R8", "late V field_start pulses", fs_cnt - fs0, 0);
    check("R8", "late V sync_err pulses", err_cnt - e0, 1);
    check("R8", "late V field_id kept", int'(field_id), 1);
    check("R4", "late V still loads v_count", int'(v_count), 1);
  endtask

  initial begin
    t_reset();
    t_no_reference();
    t_reference_lines();
    t_field_sequence();
    t_short_h();
    t_reference_update();
    t_short_v();
    t_window_miss();
    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule